// File: doc/BRIEF.md
# Synchronous Pulse-Density Frequency Modulator

This block is the digital core of a synchronous charge-balance voltage-to-frequency converter. A signed input code stands for the input voltage as a fraction of the reference. On every clock the block adds a scaled charge step to a residue accumulator and emits a one-cycle output pulse whenever the accumulated charge passes one reference quantum. The average pulse rate is therefore 0.1 + 0.8·x of the clock rate, where x is the input fraction. It is 0.1 at zero scale and 0.9 at full scale, and a small overrange is allowed beyond both ends.

The scaling is exact rather than approximate. The accumulator modulus is five times the full-scale code, so decimal densities such as 0.3 and 0.2 come out with no drift. The remainder left after each pulse is kept, so the error never accumulates. Input codes arrive on a valid/ready stream. A sample is taken on any edge where both valid and ready are high. Ready drops only while the block is powered down, and a source seeing ready low must hold its sample. The output pulse is a free-running strobe with no back-pressure: a downstream counter must take every pulse. A clock-idle input, raised by a timeout detector outside the block, puts the block into power-down. While powered down the output is held high and the residue is cleared.

Top module: `vfc_pdm_core`

## Requirements
- R1: After reset, `pulse_o` is 0, `in_ready` is 1, the held code is 0, and the residue starts from 0.
- R2: With an accepted code c (after saturation), held constant, every window of 5·1024 = 5120 consecutive cycles holds exactly 512 + 4·c output pulses. This is a density of 0.1 + 0.8·c/1024.
- R3: Code 0 gives density 0.1, code 1024 gives 0.9, code 512 gives 0.5, and code 128 gives 0.2. Code 256 gives 0.3, and starting from a zero residue its pulses fall 4, 7, 10 and 14 cycles into the run, which are gaps of 3 and 4 clocks.
- R4: `in_code` is 12-bit two's complement, with 1024 equal to the full reference. Codes below -61 are treated as -61 (density about 0.052). Codes above 1085 are treated as 1085 (density about 0.948).
- R5: `pulse_o` is registered on the rising edge and each pulse lasts exactly one cycle, unless the next edge also produces a pulse.
- R6: On every edge, the residue r and the step s = 512 + 4·c give a pulse when r + s ≥ 5120, and the new residue is r + s − 5120. Otherwise there is no pulse and the new residue is r + s.
- R7: A code is taken only on an edge with `in_valid` and `in_ready` both 1; at other times the held code is unchanged. A newly taken code sets the step used on the following edge, so its first effect on `pulse_o` is seen after the second edge from acceptance.
- R8: An edge with `clk_idle` at 1 clears the residue and suppresses the pulse. From the next edge until an edge sees `clk_idle` at 0, `pulse_o` is held at 1 and `in_ready` is 0. After release, accumulation resumes from a zero residue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_idle | input | 1 | Clock-stopped timeout flag; requests power-down |
| in_valid | input | 1 | Input code is valid |
| in_ready | output | 1 | Block accepts a code (low in power-down) |
| in_code | input | 12 | Signed input fraction, 1024 = full reference |
| pulse_o | output | 1 | Output pulse strobe, forced high in power-down |

## Verification
The hardest situation to reach from the ports combines three things. A power-down request arrives on the same edge as an accepted code. The power-down then clears a non-zero residue. Accumulation then restarts with an out-of-range code that must saturate. The stimulus drives `clk_idle` in short random bursts on top of random valid patterns and codes spread over the whole 12-bit range. Directed runs enter power-down together with a sample so that the pulse positions after release are known exactly. A cycle-exact reference model in the bench checks every cycle. Full 5120-cycle windows check the exact pulse counts at the named code points and at both saturation limits.

// File: rtl/vfc_pkg.sv
package vfc_pkg;

  // Saturate a signed code into [lo, hi].
  function automatic int vfc_sat(input int code, input int lo, input int hi);
    if (code < lo) return lo;
    if (code > hi) return hi;
    return code;
  endfunction

  // Charge step per clock for a saturated code: fs/2 + 4*code over modulus 5*fs.
  function automatic int vfc_step(input int sat_code, input int fs);
    return (fs / 2) + 4 * sat_code;
  endfunction

endpackage

// File: rtl/vfc_sample_stage.sv
module vfc_sample_stage #(
  parameter int CODE_W   = 12,
  parameter int FS_CODE  = 1024,
  parameter int OVR_CODE = 61,
  parameter int STEP_W   = 13
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pd_q,
  input  logic                     in_valid,
  input  logic signed [CODE_W-1:0] in_code,
  output logic                     in_ready,
  output logic [STEP_W-1:0]        step
);
  import vfc_pkg::*;

  localparam int LO_CODE = -OVR_CODE;
  localparam int HI_CODE = FS_CODE + OVR_CODE;

  logic signed [CODE_W-1:0] sat_c;
  logic signed [CODE_W-1:0] code_q;
  logic                     take;

  assign in_ready = ~pd_q;
  assign take     = in_valid & in_ready;

  always_comb sat_c = CODE_W'(vfc_sat(int'(in_code), LO_CODE, HI_CODE));

  always_ff @(posedge clk) begin
    if (!rst_n)    code_q <= '0;
    else if (take) code_q <= sat_c;
  end

  assign step = STEP_W'(vfc_step(int'(code_q), FS_CODE));

  // R7: code held when no handshake
  p_hold_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(code_q));

  // R4: held code always inside the saturation bounds
  p_sat_bounds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(code_q) >= LO_CODE) && (int'(code_q) <= HI_CODE));

endmodule

// File: rtl/vfc_phase_acc.sv
module vfc_phase_acc #(
  parameter int MODULUS = 5120,
  parameter int ACC_W   = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [ACC_W-1:0] step,
  output logic             carry_q
);
  localparam logic [ACC_W:0]   MOD_S = (ACC_W+1)'(MODULUS);
  localparam logic [ACC_W-1:0] MOD_A = ACC_W'(MODULUS);

  logic [ACC_W-1:0] resid;
  logic [ACC_W:0]   sum;
  logic [ACC_W:0]   wrapped;
  logic             over;

  always_comb begin
    sum     = {1'b0, resid} + {1'b0, step};
    over    = (sum >= MOD_S);
    wrapped = sum - MOD_S;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      resid   <= '0;
      carry_q <= 1'b0;
    end else if (over) begin
      resid   <= wrapped[ACC_W-1:0];
      carry_q <= 1'b1;
    end else begin
      resid   <= sum[ACC_W-1:0];
      carry_q <= 1'b0;
    end
  end

  // R6: residue stays below the modulus
  p_resid_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resid < MOD_A);

  // R6: after a pulse the residue left over is smaller than the step that caused it
  p_resid_after_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    carry_q |-> (resid < $past(step)));

  // R8: power-down request clears the residue and the pulse
  p_clear_on_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (resid == '0) && !carry_q);

endmodule

// File: rtl/vfc_out_stage.sv
module vfc_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_idle,
  input  logic carry_q,
  output logic pd_q,
  output logic pulse_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) pd_q <= 1'b0;
    else        pd_q <= clk_idle;
  end

  assign pulse_o = pd_q | carry_q;

  // R8: output held high throughout power-down
  p_pd_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pd_q |-> pulse_o);

endmodule

// File: rtl/vfc_pdm_core.sv
module vfc_pdm_core #(
  parameter int CODE_W   = 12,
  parameter int FS_CODE  = 1024,
  parameter int OVR_CODE = 61
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clk_idle,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [CODE_W-1:0] in_code,
  output logic                     pulse_o
);
  localparam int MODULUS = 5 * FS_CODE;
  localparam int ACC_W   = $clog2(MODULUS);

  logic [ACC_W-1:0] step;
  logic             carry_q;
  logic             pd_q;

  vfc_sample_stage #(
    .CODE_W(CODE_W), .FS_CODE(FS_CODE), .OVR_CODE(OVR_CODE), .STEP_W(ACC_W)
  ) u_sample (
    .clk(clk), .rst_n(rst_n), .pd_q(pd_q), .in_valid(in_valid),
    .in_code(in_code), .in_ready(in_ready), .step(step)
  );

  vfc_phase_acc #(.MODULUS(MODULUS), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(clk_idle), .step(step), .carry_q(carry_q)
  );

  vfc_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .clk_idle(clk_idle), .carry_q(carry_q),
    .pd_q(pd_q), .pulse_o(pulse_o)
  );

  // R8: an idle edge gives high output and no ready on the next cycle
  p_idle_effect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_idle |=> pulse_o && !in_ready);

  // R1: first cycle after reset is quiet and ready
  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> !pulse_o && in_ready);

endmodule

// File: tb/vfc_pdm_core_test.sv
`timescale 1ns/1ps
module vfc_pdm_core_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_idle = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [11:0] in_code = '0;
  logic pulse_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // model state (from the requirements)
  int m_res = 0;
  int m_code = 0;
  bit m_pd = 1'b0;
  bit m_pulse = 1'b0;
  bit last_out;

  always #5 clk = ~clk;

  vfc_pdm_core uut (
    .clk(clk), .rst_n(rst_n), .clk_idle(clk_idle), .in_valid(in_valid),
    .in_ready(in_ready), .in_code(in_code), .pulse_o(pulse_o)
  );

  function automatic int sat_ref(input int c);   // R4 bounds
    if (c < -61) return -61;
    if (c > 1085) return 1085;
    return c;
  endfunction

  function automatic int step_ref(input int c);  // R2 step
    return 512 + 4 * c;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_res = 0; m_code = 0; m_pd = 0; m_pulse = 0;
  endtask

  // one cycle: sample outputs, drive next inputs, advance model over next edge
  task automatic cyc(input bit v, input int c, input bit idle, input string req);
    int sum;
    bit nxt_pd;
    @(negedge clk);
    last_out = pulse_o;
    check({req, " pulse_o"}, int'(pulse_o), int'(m_pd | m_pulse));
    check("R7/R8 in_ready", int'(in_ready), int'(!m_pd));
    in_valid = v;
    in_code  = 12'(c);
    clk_idle = idle;
    sum = m_res + step_ref(m_code);
    nxt_pd = idle;
    if (idle) begin
      m_res = 0; m_pulse = 0;
    end else if (sum >= 5120) begin
      m_res = sum - 5120; m_pulse = 1;
    end else begin
      m_res = sum; m_pulse = 0;
    end
    if (v && !m_pd) m_code = sat_ref(c);
    m_pd = nxt_pd;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 0; clk_idle = 0; in_code = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  // R2/R3/R4: count pulses over one full 5120-cycle window
  task automatic density(input int c, input string req);
    int cnt = 0;
    cyc(1, c, 0, req);
    cyc(0, 0, 0, req);
    for (int k = 0; k < 5120; k++) begin
      cyc(0, 0, 0, req);
      if (last_out) cnt++;
    end
    check({req, " window count"}, cnt, step_ref(sat_ref(c)));
  endtask

  initial begin
    int pos[$];
    process::self().srandom(32'd1234);
    do_reset();
    // R1: reset state
    @(negedge clk);
    check("R1 pulse_o after reset", int'(pulse_o), 0);
    check("R1 in_ready after reset", int'(in_ready), 1);

    // R3: pulse positions for code 256 from zero residue via power-down
    cyc(1, 256, 1, "R8");
    cyc(0, 0, 0, "R8");
    check("R8 output high in power-down", int'(last_out), 1);
    for (int k = 1; k <= 14; k++) begin
      cyc(0, 0, 0, "R3");
      if (last_out) pos.push_back(k);
    end
    check("R3 pulse count in 14 cycles", pos.size(), 4);
    if (pos.size() == 4) begin
      check("R3 first pulse", pos[0], 4);
      check("R3 second pulse", pos[1], 7);
      check("R3 third pulse", pos[2], 10);
      check("R3 fourth pulse", pos[3], 14);
    end

    density(0, "R3 zero scale");
    density(1024, "R3 full scale");
    density(512, "R3 half scale");
    density(256, "R3 quarter scale");
    density(128, "R3 eighth scale");
    density(-2048, "R4 low saturation");
    density(2047, "R4 high saturation");
    density(-61, "R4 low bound");
    density(1085, "R2 upper overrange");
    density(333, "R2 odd code");

    // R7: valid low ignored; held code unchanged over window
    cyc(1, 700, 0, "R7");
    for (int k = 0; k < 40; k++) cyc(0, -500, 0, "R7 valid low ignored");

    // R5/R6/R7/R8: constrained random
    for (int k = 0; k < 6000; k++) begin
      bit v = ($urandom_range(1) == 1);
      int c = ($urandom_range(9) < 2) ? ($urandom_range(4095) - 2048)
                                      : ($urandom_range(1200) - 80);
      bit idle = ($urandom_range(99) < 3);
      cyc(v, c, idle, "R6 random");
      if (idle) begin
        int n = $urandom_range(4);
        for (int j = 0; j < n; j++) cyc($urandom_range(1) == 1, c, 1, "R8 random idle");
      end
    end

    // R1: reset in mid-stream
    do_reset();
    @(negedge clk);
    check("R1 pulse_o after second reset", int'(pulse_o), 0);
    check("R1 in_ready after second reset", int'(in_ready), 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule